// File: doc/BRIEF.md
# Buffered Flash Page-Program Engine

This block writes data into a serial NOR flash over a single-data-line SPI link. Software first loads a program opcode, a flash address and a mode word through a small word-wide register port. In full-page mode it then streams one page of data, four bytes per write, into a data port. A single start write then makes the engine run the whole sequence by itself: an optional write-enable command in its own chip-select window, the program window (opcode, address, data), and optional status polling until the flash reports that the write is finished.

With full-page mode off, the program window carries a single data byte taken from a dedicated register. Mode changes take effect only while the engine is idle, so software confirms a change by reading the mode register back until it shows the requested value.

Register map (byte offsets, 32-bit data): 0x00 control (write bit 0 = start; read bit 0 = busy), 0x04 mode, 0x08 program opcode [7:0], 0x0C flash address [31:0], 0x10 single data byte [7:0], 0x14 page data port (write only, reads zero).

Top module: `pgp_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the control register reads busy = 0 and the mode register reads 0.
- R2: The mode register (bit 0 full-page, bit 1 four-byte address, bit 2 skip write-enable, bit 3 skip status poll) reads back a written value within four cycles while idle; a value written while busy does not show or take effect until the operation ends.
- R3: Unless bit 2 of the mode is set, the operation begins with a chip-select window holding exactly one byte, 0x06, followed by chip select high for at least one cycle before the program window.
- R4: The program window begins with the opcode register byte, followed by the address sent most significant byte first: the low three address bytes, or all four when mode bit 1 is set.
- R5: In full-page mode the program window carries exactly 128 data bytes after the address; data-port word k supplies page bytes 4k to 4k+3, bits [7:0] being byte 4k, and bytes go out in ascending order.
- R6: With full-page mode off, the program window carries exactly one data byte, the value of the single-byte register.
- R7: Data-port writes beyond the 32nd word since the last start are dropped; a start resets the word position to 0, and page bytes that were not rewritten keep their previous contents.
- R8: Unless bit 3 of the mode is set, after the program window the engine opens two-byte windows (0x05 then a read byte) until a read byte has bit 0 clear; each window sees chip select high between them. With bit 3 set, no such windows follow.
- R9: The control register reads busy = 1 from the start write until the last window closes; while busy, start writes and writes to the opcode, address, single-byte and data-port registers are ignored.
- R10: The link uses clock-idle-low timing: each bit is driven while the serial clock is low and held stable while it is high, the flash output is sampled on the rising clock, and the clock only toggles inside a chip-select window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench sweeps all sixteen mode combinations with a flash model that captures every chip-select window and reports busy for a varying number of polls, so a design that swaps address byte order or counts three bytes in four-byte mode, packs page words big-endian, forgets a gap between windows or stops polling one read too early shows wrong window contents or counts. It writes 34 page words before a start to catch a pointer that wraps over word 0, then only two words to catch a pointer not reset at start or a buffer that clears itself. It also writes opcode, mode and start during a long poll, which a design without the busy lockout would turn into a corrupted later opcode, an early mode change or a second program.

// File: rtl/pgp_pkg.sv
package pgp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WREN,
      ST_PROG,
      ST_POLL,
      ST_GAP
   } seq_state_t;

   // bit 0 full-page, bit 1 four-byte address, bit 2 skip write-enable, bit 3 skip poll
   typedef struct packed {
      logic no_poll;
      logic no_wren;
      logic addr4;
      logic buf_en;
   } mode_t;

   localparam logic [7:0] OPC_WREN = 8'h06;
   localparam logic [7:0] OPC_RDSR = 8'h05;

   localparam logic [7:0] OFS_CTRL   = 8'h00;
   localparam logic [7:0] OFS_MODE   = 8'h04;
   localparam logic [7:0] OFS_OPC    = 8'h08;
   localparam logic [7:0] OFS_ADDR   = 8'h0C;
   localparam logic [7:0] OFS_SINGLE = 8'h10;
   localparam logic [7:0] OFS_PORT   = 8'h14;

endpackage

// File: rtl/pgp_shifter.sv
module pgp_shifter (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] din,
   input  logic       miso,
   output logic       busy,
   output logic       sck,
   output logic       mosi,
   output logic       rx_last
);

   logic [7:0] sh_q;
   logic [2:0] cnt_q;
   logic       ph_q;
   logic       act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         cnt_q   <= '0;
         ph_q    <= 1'b0;
         act_q   <= 1'b0;
         rx_last <= 1'b0;
      end else if (go && !act_q) begin
         sh_q  <= din;
         cnt_q <= '0;
         ph_q  <= 1'b0;
         act_q <= 1'b1;
      end else if (act_q) begin
         if (!ph_q) begin
            ph_q    <= 1'b1;
            rx_last <= miso;
         end else begin
            ph_q  <= 1'b0;
            sh_q  <= {sh_q[6:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 3'd7) act_q <= 1'b0;
         end
      end
   end

   assign busy = act_q;
   assign sck  = ph_q;
   assign mosi = sh_q[7];

   a_r10_mosi_held: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> $stable(mosi));
   a_r10_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !act_q |=> !sck);

endmodule

// File: rtl/pgp_regs.sv
module pgp_regs import pgp_pkg::*; #(
   parameter int PAGE_BYTES = 128,
   parameter int REG_AW     = 8,
   parameter bit ADDR4_EN   = 1'b1,
   localparam int BIW       = $clog2(PAGE_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [REG_AW-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic              busy,
   input  logic [BIW-1:0]    byte_idx,
   output logic [31:0]       rdata,
   output logic              start,
   output mode_t             mode_q,
   output logic [7:0]        opcode_q,
   output logic [31:0]       addr_q,
   output logic [7:0]        single_q,
   output logic [7:0]        byte_out
);

   localparam int WORDS = PAGE_BYTES / 4;
   localparam int IW    = $clog2(WORDS);
   localparam int PW    = $clog2(WORDS + 1);

   if (PAGE_BYTES < 8 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 8");
   end
   if (REG_AW < 5) begin : g_bad_aw
      $error("REG_AW must cover the register map");
   end

   logic [31:0]   mem [WORDS];
   logic [PW-1:0] wptr_q;
   mode_t         mode_pend_q;
   mode_t         mode_in;
   logic          wr_ok;

   if (ADDR4_EN) begin : g_addr4
      assign mode_in = mode_t'(wdata[3:0]);
   end else begin : g_addr3
      assign mode_in = mode_t'({wdata[3:2], 1'b0, wdata[0]});
   end

   function automatic logic hit(input logic [REG_AW-1:0] a, input logic [7:0] ofs);
      return a == REG_AW'(ofs);
   endfunction

   assign wr_ok = we && !busy;
   assign start = wr_ok && hit(addr, OFS_CTRL) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q      <= '0;
         mode_pend_q <= '0;
         mode_q      <= '0;
         opcode_q    <= '0;
         addr_q      <= '0;
         single_q    <= '0;
      end else begin
         if (we && hit(addr, OFS_MODE)) mode_pend_q <= mode_in;
         if (!busy) mode_q <= mode_pend_q;
         if (wr_ok && hit(addr, OFS_OPC))    opcode_q <= wdata[7:0];
         if (wr_ok && hit(addr, OFS_ADDR))   addr_q   <= wdata;
         if (wr_ok && hit(addr, OFS_SINGLE)) single_q <= wdata[7:0];
         if (start) wptr_q <= '0;
         else if (wr_ok && hit(addr, OFS_PORT) && wptr_q < PW'(WORDS)) wptr_q <= wptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok && hit(addr, OFS_PORT) && wptr_q < PW'(WORDS))
         mem[wptr_q[IW-1:0]] <= wdata;
   end

   assign byte_out = 8'(mem[byte_idx[BIW-1:2]] >> (8 * byte_idx[1:0]));

   always_comb begin
      rdata = '0;
      if (hit(addr, OFS_CTRL))   rdata = {31'b0, busy};
      if (hit(addr, OFS_MODE))   rdata = {28'b0, mode_q};
      if (hit(addr, OFS_OPC))    rdata = {24'b0, opcode_q};
      if (hit(addr, OFS_ADDR))   rdata = addr_q;
      if (hit(addr, OFS_SINGLE)) rdata = {24'b0, single_q};
   end

   a_r7_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      wptr_q <= PW'(WORDS));
   a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mode_q));

endmodule

// File: rtl/pgp_seq.sv
module pgp_seq import pgp_pkg::*; #(
   parameter int PAGE_BYTES = 128,
   localparam int BIW       = $clog2(PAGE_BYTES),
   localparam int CW        = $clog2(PAGE_BYTES + 6)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  mode_t          mode,
   input  logic [7:0]     opcode,
   input  logic [31:0]    addr_word,
   input  logic [7:0]     single_byte,
   input  logic [7:0]     buf_byte,
   input  logic           sh_busy,
   input  logic           poll_wip,
   output logic           busy,
   output logic           cs_n,
   output logic           go,
   output logic [7:0]     tx_byte,
   output logic [BIW-1:0] byte_idx
);

   seq_state_t     state_q, gap_next_q;
   logic [CW-1:0]  idx_q, alen, dlen, plen;
   logic [BIW-1:0] didx_q;
   logic [7:0]     abyte;

   always_comb begin
      alen    = mode.addr4  ? CW'(4) : CW'(3);
      dlen    = mode.buf_en ? CW'(PAGE_BYTES) : CW'(1);
      plen    = CW'(1) + alen + dlen;
      abyte   = 8'(addr_word >> (8 * (alen - idx_q)));
      tx_byte = 8'h00;
      go      = 1'b0;
      unique case (state_q)
         ST_WREN: begin
            tx_byte = OPC_WREN;
            go      = !sh_busy && idx_q == '0;
         end
         ST_PROG: begin
            if (idx_q == '0)      tx_byte = opcode;
            else if (idx_q <= alen) tx_byte = abyte;
            else                  tx_byte = mode.buf_en ? buf_byte : single_byte;
            go = !sh_busy && idx_q < plen;
         end
         ST_POLL: begin
            tx_byte = (idx_q == '0) ? OPC_RDSR : 8'h00;
            go      = !sh_busy && idx_q < CW'(2);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         gap_next_q <= ST_IDLE;
         idx_q      <= '0;
         didx_q     <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start) begin
               state_q <= mode.no_wren ? ST_PROG : ST_WREN;
               idx_q   <= '0;
               didx_q  <= '0;
            end
            ST_WREN: begin
               if (go) idx_q <= idx_q + 1'b1;
               else if (!sh_busy && idx_q != '0) begin
                  state_q    <= ST_GAP;
                  gap_next_q <= ST_PROG;
               end
            end
            ST_PROG: begin
               if (go) begin
                  idx_q <= idx_q + 1'b1;
                  if (idx_q > alen) didx_q <= didx_q + 1'b1;
               end else if (!sh_busy && idx_q == plen) begin
                  if (mode.no_poll) state_q <= ST_IDLE;
                  else begin
                     state_q    <= ST_GAP;
                     gap_next_q <= ST_POLL;
                  end
               end
            end
            ST_POLL: begin
               if (go) idx_q <= idx_q + 1'b1;
               else if (!sh_busy && idx_q == CW'(2)) begin
                  if (poll_wip) begin
                     state_q    <= ST_GAP;
                     gap_next_q <= ST_POLL;
                  end else state_q <= ST_IDLE;
               end
            end
            default: begin
               state_q <= gap_next_q;
               idx_q   <= '0;
            end
         endcase
      end
   end

   assign busy     = state_q != ST_IDLE;
   assign cs_n     = !(state_q == ST_WREN || state_q == ST_PROG || state_q == ST_POLL);
   assign byte_idx = didx_q;

   a_r3_gap_shifter_idle: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_GAP |-> !sh_busy);

endmodule

// File: rtl/pgp_engine.sv
module pgp_engine import pgp_pkg::*; #(
   parameter int PAGE_BYTES = 128,
   parameter int REG_AW     = 8,
   parameter bit ADDR4_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              spi_cs_n,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso
);

   localparam int BIW = $clog2(PAGE_BYTES);

   logic           start, busy, go, sh_busy, rx_last;
   mode_t          mode;
   logic [7:0]     opcode, single_byte, buf_byte, tx_byte;
   logic [31:0]    addr_word;
   logic [BIW-1:0] byte_idx;

   pgp_regs #(.PAGE_BYTES(PAGE_BYTES), .REG_AW(REG_AW), .ADDR4_EN(ADDR4_EN)) i_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .busy(busy), .byte_idx(byte_idx), .rdata(reg_rdata), .start(start),
      .mode_q(mode), .opcode_q(opcode), .addr_q(addr_word), .single_q(single_byte),
      .byte_out(buf_byte)
   );

   pgp_seq #(.PAGE_BYTES(PAGE_BYTES)) i_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opcode(opcode),
      .addr_word(addr_word), .single_byte(single_byte), .buf_byte(buf_byte),
      .sh_busy(sh_busy), .poll_wip(rx_last), .busy(busy), .cs_n(spi_cs_n),
      .go(go), .tx_byte(tx_byte), .byte_idx(byte_idx)
   );

   pgp_shifter i_shifter (
      .clk(clk), .rst_n(rst_n), .go(go), .din(tx_byte), .miso(spi_miso),
      .busy(sh_busy), .sck(spi_sck), .mosi(spi_mosi), .rx_last(rx_last)
   );

   a_r10_shift_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      sh_busy |-> !spi_cs_n);
   a_r9_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !start);

endmodule

// File: tb/test_pgp_engine.sv
module test_pgp_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;

   int nchecks = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pgp_engine i_pgp_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   // flash model: records every chip-select window
   logic [7:0] win_b [8][140];
   int         win_len [8];
   int         nwin = 0;
   logic [7:0] shreg = '0;
   logic [2:0] bitc = '0;
   int         poll_left = 0;
   logic [7:0] stat;

   assign stat = (poll_left > 0) ? 8'h03 : 8'h02;
   assign spi_miso = (!spi_cs_n && nwin < 8 && win_len[nwin] == 1) ? stat[3'd7 - bitc] : 1'b0;

   always @(negedge spi_cs_n) begin
      bitc = '0;
      if (nwin < 8) win_len[nwin] = 0;
   end

   always @(posedge spi_sck) begin
      if (!spi_cs_n && nwin < 8) begin
         shreg = {shreg[6:0], spi_mosi};
         if (bitc == 3'd7) begin
            if (win_len[nwin] < 140) win_b[nwin][win_len[nwin]] = shreg;
            win_len[nwin] = win_len[nwin] + 1;
         end
         bitc = bitc + 3'd1;
      end
   end

   always @(posedge spi_cs_n) begin
      if (rst_n && nwin < 8) begin
         if (win_len[nwin] > 0 && win_b[nwin][0] == 8'h05 && poll_left > 0)
            poll_left = poll_left - 1;
         nwin = nwin + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchecks++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic clear_log();
      nwin = 0;
      for (int i = 0; i < 8; i++) win_len[i] = 0;
   endtask

   task automatic set_mode(input logic [3:0] m);
      logic [31:0] d;
      bit ok = 1'b0;
      wr(8'h04, {28'b0, m});
      for (int i = 0; i < 4; i++) begin
         rd(8'h04, d);
         if (d[3:0] == m) ok = 1'b1;
         if (ok) break;
      end
      chk(ok, "R2", "mode read-back", int'(d), int'(m));
   endtask

   task automatic wait_idle();
      logic [31:0] d;
      for (int i = 0; i < 20000; i++) begin
         rd(8'h00, d);
         if (d[0] == 1'b0) break;
      end
      repeat (5) @(negedge clk);
   endtask

   task automatic run_op(input int p);
      poll_left = p;
      clear_log();
      wr(8'h00, 32'h1);
      wait_idle();
   endtask

   logic [7:0]  exp_buf [128];
   logic [31:0] addr_val = 32'hA1B2C3D4;
   logic [7:0]  opc_val  = 8'h02;
   logic [7:0]  single_val = 8'h5A;

   task automatic fill_page(input int seed, input int nwords);
      for (int k = 0; k < nwords; k++) begin
         logic [7:0] b [4];
         for (int j = 0; j < 4; j++) begin
            b[j] = 8'((4 * k + j) * 13 + seed * 29 + 1);
            if (k < 32) exp_buf[4 * k + j] = b[j];
         end
         wr(8'h14, {b[3], b[2], b[1], b[0]});
      end
   endtask

   task automatic check_windows(input logic [3:0] m, input int p, input logic [7:0] opc);
      int w = 0;
      int alen = m[1] ? 4 : 3;
      int dlen = m[0] ? 128 : 1;
      int bad, fa, fe;
      if (!m[2]) begin
         chk(win_len[0] == 1 && win_b[0][0] == 8'h06, "R3", "write-enable window",
             win_len[0] == 1 ? int'(win_b[0][0]) : win_len[0], 8'h06);
         w = 1;
      end
      chk(win_len[w] == 1 + alen + dlen, m[0] ? "R5" : "R6", "program window length",
          win_len[w], 1 + alen + dlen);
      bad = 0; fa = 0; fe = 0;
      for (int j = 0; j <= alen; j++) begin
         logic [7:0] e = (j == 0) ? opc : 8'(addr_val >> (8 * (alen - j)));
         if (win_b[w][j] !== e && bad == 0) begin bad = 1; fa = int'(win_b[w][j]); fe = int'(e); end
      end
      chk(bad == 0, "R4", "opcode and address bytes", fa, fe);
      bad = 0;
      for (int j = 0; j < dlen; j++) begin
         logic [7:0] e = m[0] ? exp_buf[j] : single_val;
         if (win_b[w][1 + alen + j] !== e && bad == 0) begin
            bad = 1; fa = int'(win_b[w][1 + alen + j]); fe = int'(e);
         end
      end
      chk(bad == 0, m[0] ? "R5" : "R6", "data bytes", fa, fe);
      w++;
      if (!m[3]) begin
         bad = 0;
         for (int i = 0; i <= p; i++)
            if (win_len[w + i] != 2 || win_b[w + i][0] != 8'h05) bad = 1;
         chk(bad == 0, "R8", "status poll windows", bad, 0);
         w = w + p + 1;
      end
      chk(nwin == w, "R8", "window count", nwin, w);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchecks++; nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      clear_log();
      repeat (3) @(negedge clk);
      #1;
      chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1", "link idle in reset",
          int'({spi_cs_n, spi_sck}), 2);
      rst_n = 1'b1;
      rd(8'h00, d);
      chk(d === 32'h0, "R1", "busy after reset", int'(d), 0);
      rd(8'h04, d);
      chk(d === 32'h0, "R1", "mode after reset", int'(d), 0);
      chk(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1", "link idle after reset",
          int'({spi_cs_n, spi_sck}), 2);

      wr(8'h08, {24'b0, opc_val});
      wr(8'h0C, addr_val);
      wr(8'h10, {24'b0, single_val});

      // sweep every mode combination, R3 R4 R5 R6 R8 R10
      for (int m = 0; m < 16; m++) begin
         set_mode(4'(m));
         if (m[0]) fill_page(m, 32);
         run_op(m % 3);
         check_windows(4'(m), m % 3, opc_val);
      end

      // R7: overflow words dropped
      set_mode(4'hD);
      fill_page(40, 34);
      run_op(0);
      check_windows(4'hD, 0, opc_val);
      // R7: pointer reset at start, untouched bytes kept
      fill_page(77, 2);
      run_op(0);
      check_windows(4'hD, 0, opc_val);

      // R9 / R2: writes during busy
      set_mode(4'h1);
      fill_page(3, 32);
      poll_left = 3;
      clear_log();
      wr(8'h00, 32'h1);
      rd(8'h00, d);
      chk(d[0] === 1'b1, "R9", "busy after start", int'(d), 1);
      wr(8'h08, 32'h77);
      wr(8'h04, 32'hD);
      wr(8'h14, 32'hDEADBEEF);
      wr(8'h00, 32'h1);
      rd(8'h04, d);
      chk(d[3:0] == 4'h1, "R2", "mode held while busy", int'(d), 1);
      wait_idle();
      check_windows(4'h1, 3, opc_val);
      repeat (300) @(negedge clk);
      chk(nwin == 6, "R9", "no second operation from busy start", nwin, 6);
      rd(8'h04, d);
      rd(8'h04, d);
      chk(d[3:0] == 4'hD, "R2", "mode applied after operation", int'(d), 4'hD);
      run_op(0);
      check_windows(4'hD, 0, opc_val);
      rd(8'h08, d);
      chk(d[7:0] == opc_val, "R9", "opcode write during busy ignored", int'(d), int'(opc_val));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
   end

endmodule